// File: doc/BRIEF.md
# Indirect Register Port with Bitfield Access

The block puts a two-location host window in front of a register array organised as registers by channels. The host first loads a pointer word naming a register, a channel and, optionally, a bitfield descriptor. It then reads or writes the data location. A plain pointer moves whole 32-bit words. A pointer with a descriptor makes the hardware extract the field on a read. On a write it performs the read-modify-write itself, so that only the field's bits change and the host never has to merge words. Pointers that name reserved bits, a register outside the array or a channel outside the array are rejected. The same holds for field writes whose data does not fit the field. A rejected access produces an error pulse and sets a sticky error bit.

Pointer layout: bits 31:30 reserved, bits 29:24 field width, bits 23:16 descriptor area (offset in 20:16, bits 23:21 reserved), bits 15:8 register index, bits 7:0 channel. When bits 31:24 are all zero, the access is plain and bits 23:16 must be zero.

Requests use valid/ready. The block accepts a request in every cycle unless it holds a read response the host has not taken: while `rsp_valid` is high and `rsp_ready` is low, `req_ready` stays low. A held response keeps its data unchanged until the host takes it. Writes produce no response.

Top module: `ind_reg_port`

## Requirements
- R1: After reset every stored word, the pointer, `rsp_valid`, `err_pulse` and `err_sticky` are zero.
- R2: A write with `req_sel`=0 loads the pointer; a read with `req_sel`=0 returns the pointer word.
- R3: With pointer bits 31:24 zero, a data-location write stores the whole 32-bit word at the register in pointer bits 15:8 and the channel in bits 7:0, and a data-location read returns it.
- R4: With pointer bits 31:24 nonzero, a data read returns the stored word shifted right by the offset in bits 20:16 and masked to the width in bits 29:24.
- R5: An accepted bitfield write replaces only the stored bits under the mask shifted left by the offset, with the data shifted by the same amount; all other bits keep their value.
- R6: A bitfield write whose data has a bit set above the field width is rejected, leaves the stored word unchanged and raises the error.
- R7: A field width of 32 or more uses an all-ones mask.
- R8: A data access is rejected when pointer bits 31:30 are nonzero, when reserved descriptor bits are set (23:16 for a plain pointer, 23:21 for a field pointer), or when the register index is at least the number of registers or the channel is at least the number of channels. A rejected read returns zero and a rejected write changes no stored word.
- R9: Each rejected access raises `err_pulse` for exactly the cycle after acceptance and sets `err_sticky`, which stays set until reset.
- R10: A read response appears on the cycle after acceptance. It is held with stable data while `rsp_ready` is low, and `req_ready` is low for as long as it is held.
- R11: Different channels of one register hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_sel | input | 1 | 0 = pointer location, 1 = data location |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle flag for a rejected access |
| err_sticky | output | 1 | Set by any rejected access, cleared only by reset |

## Verification
The hardest case to reach is a rejected field write that must leave the word untouched. From the ports it looks just like an accepted write, except that the stored value does not change. The stimulus therefore stores a known word with a plain pointer, narrows the pointer to a field, sends data one bit too wide for it, and then widens the pointer again to read the whole word back. Channel and register aliasing is reached the same way: an out-of-range channel write is followed by a read of the channel it would alias to if the index were truncated.

// File: rtl/irp_pkg.sv
package irp_pkg;

  localparam int WORD_W = 32;
  localparam int WID_W  = 6;
  localparam int OFS_W  = 5;
  localparam int IDX_W  = 8;

  typedef enum logic {
    SEL_PTR  = 1'b0,
    SEL_DATA = 1'b1
  } port_sel_e;

  typedef struct packed {
    logic             legal;
    logic             is_field;
    logic [WID_W-1:0] width;
    logic [OFS_W-1:0] offset;
    logic [IDX_W-1:0] reg_idx;
    logic [IDX_W-1:0] chan;
  } ptr_info_t;

  function automatic logic [WORD_W-1:0] width_mask(input logic [WID_W-1:0] w);
    logic [WORD_W-1:0] m;
    if (int'(w) >= WORD_W) m = '1;
    else                   m = (WORD_W'(1) << w) - WORD_W'(1);
    return m;
  endfunction

endpackage

// File: rtl/irp_ptr_decode.sv
module irp_ptr_decode
  import irp_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_CHANS = 16
) (
  input  logic [WORD_W-1:0] ptr,
  output ptr_info_t         info
);

  logic top_bad, rsv_bad, reg_bad, chan_bad, field;

  always_comb begin
    field    = |ptr[31:24];
    top_bad  = |ptr[31:30];
    rsv_bad  = field ? (|ptr[23:21]) : (|ptr[23:16]);
    reg_bad  = 32'(ptr[15:8]) >= 32'(NUM_REGS);
    chan_bad = 32'(ptr[7:0])  >= 32'(NUM_CHANS);

    info.legal    = !(top_bad || rsv_bad || reg_bad || chan_bad);
    info.is_field = field;
    info.width    = ptr[29:24];
    info.offset   = ptr[20:16];
    info.reg_idx  = ptr[15:8];
    info.chan     = ptr[7:0];
  end

endmodule

// File: rtl/irp_field_unit.sv
module irp_field_unit
  import irp_pkg::*;
(
  input  logic              is_field,
  input  logic [WID_W-1:0]  width,
  input  logic [OFS_W-1:0]  offset,
  input  logic [WORD_W-1:0] stored,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_val,
  output logic [WORD_W-1:0] wr_val,
  output logic              reject
);

  logic [WORD_W-1:0] mask, smask;

  always_comb begin
    mask  = width_mask(width);
    smask = mask << offset;
    if (is_field) begin
      rd_val = (stored >> offset) & mask;
      reject = |(wdata & ~mask);
      wr_val = (stored & ~smask) | ((wdata << offset) & smask);
    end else begin
      rd_val = stored;
      reject = 1'b0;
      wr_val = wdata;
    end
  end

endmodule

// File: rtl/irp_store.sv
module irp_store
  import irp_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_CHANS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [IDX_W-1:0]  chan,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = NUM_REGS * NUM_CHANS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [31:0]       lin;
  logic              in_range;
  logic [AW-1:0]     addr;

  always_comb begin
    lin      = 32'(reg_idx) * 32'(NUM_CHANS) + 32'(chan);
    in_range = (32'(reg_idx) < 32'(NUM_REGS)) && (32'(chan) < 32'(NUM_CHANS));
    addr     = AW'(lin);
    rd_data  = in_range ? mem[addr] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && in_range) begin
      mem[addr] <= wr_data;
    end
  end

  // R3: a write lands at the addressed word
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_range) |=> (mem[$past(addr)] == $past(wr_data)));

endmodule

// File: rtl/ind_reg_port.sv
module ind_reg_port
  import irp_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_CHANS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_sel,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        err_pulse,
  output logic        err_sticky
);

  logic [WORD_W-1:0] ptr_q;
  ptr_info_t         info;
  logic [WORD_W-1:0] st_rd, fu_rd, fu_wr;
  logic              fu_reject;
  logic              accept, data_acc, bad, st_wr_en;

  irp_ptr_decode #(.NUM_REGS(NUM_REGS), .NUM_CHANS(NUM_CHANS)) u_dec (
    .ptr  (ptr_q),
    .info (info)
  );

  irp_store #(.NUM_REGS(NUM_REGS), .NUM_CHANS(NUM_CHANS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (st_wr_en),
    .reg_idx (info.reg_idx),
    .chan    (info.chan),
    .wr_data (fu_wr),
    .rd_data (st_rd)
  );

  irp_field_unit u_field (
    .is_field (info.is_field),
    .width    (info.width),
    .offset   (info.offset),
    .stored   (st_rd),
    .wdata    (req_wdata),
    .rd_val   (fu_rd),
    .wr_val   (fu_wr),
    .reject   (fu_reject)
  );

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    data_acc  = accept && (port_sel_e'(req_sel) == SEL_DATA);
    bad       = !info.legal || (req_write && fu_reject);
    st_wr_en  = data_acc && req_write && !bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      err_pulse <= data_acc && bad;
      if (data_acc && bad) err_sticky <= 1'b1;
      if (accept && req_write && port_sel_e'(req_sel) == SEL_PTR)
        ptr_q <= req_wdata;
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        if (port_sel_e'(req_sel) == SEL_PTR) rsp_rdata <= ptr_q;
        else                                 rsp_rdata <= info.legal ? fu_rd : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R10: response timing and back-pressure
  p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> rsp_valid);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  p_bp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  // R9: sticky never clears, pulse implies sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_sticky));
  p_pulse_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);
  // R5: a field write keeps bits outside the shifted mask
  p_field_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_en && info.is_field) |->
      (((fu_wr ^ st_rd) & ~(width_mask(info.width) << info.offset)) == '0));
  // R6: oversize field data is flagged
  p_reject_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && req_write && info.is_field && fu_reject) |=> err_pulse);
  // R8: rejected read returns zero
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !req_write && !info.legal) |=> (err_pulse && rsp_rdata == '0));

endmodule

// File: tb/ind_reg_port_tb.sv
`timescale 1ns/1ps
module ind_reg_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_sel = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        err_pulse;
  logic        err_sticky;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ind_reg_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 32'h00000305, 32'h0,        1'b0, 4'd3},
    '{1'b1, 1'b1, 32'hA5A51234, 32'h0,        1'b0, 4'd3},
    '{1'b1, 1'b0, 32'h0,        32'hA5A51234, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b0, 32'h0,        32'h00000305, 1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 32'h08080305, 32'h0,        1'b0, 4'd4},
    '{1'b1, 1'b0, 32'h0,        32'h00000012, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b1, 32'h0000003C, 32'h0,        1'b0, 4'd5},
    '{1'b1, 1'b1, 32'h000001FF, 32'h0,        1'b1, 4'd6},  // R6
    '{1'b1, 1'b0, 32'h0,        32'h0000003C, 1'b0, 4'd6},  // R6
    '{1'b0, 1'b1, 32'h00000305, 32'h0,        1'b0, 4'd5},
    '{1'b1, 1'b0, 32'h0,        32'hA5A53C34, 1'b0, 4'd5},  // R5
    '{1'b0, 1'b1, 32'h00000306, 32'h0,        1'b0, 4'd11},
    '{1'b1, 1'b0, 32'h0,        32'h00000000, 1'b0, 4'd11}, // R11
    '{1'b0, 1'b1, 32'h28040305, 32'h0,        1'b0, 4'd7},
    '{1'b1, 1'b0, 32'h0,        32'h0A5A53C3, 1'b0, 4'd7},  // R7
    '{1'b1, 1'b1, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd7},
    '{1'b0, 1'b1, 32'h00000305, 32'h0,        1'b0, 4'd7},
    '{1'b1, 1'b0, 32'h0,        32'hFFFFFFF4, 1'b0, 4'd7},  // R7
    '{1'b0, 1'b1, 32'h00001000, 32'h0,        1'b0, 4'd8},
    '{1'b1, 1'b0, 32'h0,        32'h00000000, 1'b1, 4'd8},  // R8 register out of range
    '{1'b0, 1'b1, 32'h00000310, 32'h0,        1'b0, 4'd8},
    '{1'b1, 1'b1, 32'h00000077, 32'h0,        1'b1, 4'd8},  // R8 channel out of range
    '{1'b0, 1'b1, 32'h00000300, 32'h0,        1'b0, 4'd8},
    '{1'b1, 1'b0, 32'h0,        32'h00000000, 1'b0, 4'd8},  // R8 no alias write
    '{1'b0, 1'b1, 32'h00010305, 32'h0,        1'b0, 4'd8},
    '{1'b1, 1'b0, 32'h0,        32'h00000000, 1'b1, 4'd8},  // R8 reserved plain bits
    '{1'b0, 1'b1, 32'h40000305, 32'h0,        1'b0, 4'd8},
    '{1'b1, 1'b0, 32'h0,        32'h00000000, 1'b1, 4'd8},  // R8 top bits
    '{1'b0, 1'b1, 32'h08200305, 32'h0,        1'b0, 4'd8},
    '{1'b1, 1'b0, 32'h0,        32'h00000000, 1'b1, 4'd8}   // R8 reserved field bits
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // drive one request at the falling edge, sample at the next falling edge
  task automatic op(input logic sel, input logic wr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 err_sticky", 32'(err_sticky), 32'd0);
    op(1'b0, 1'b0, 32'h0);
    chk("R1 pointer", rsp_rdata, 32'h0);
    op(1'b1, 1'b0, 32'h0);
    chk("R1 storage", rsp_rdata, 32'h0);
    chk("R1 err_pulse", 32'(err_pulse), 32'd0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].sel, VEC[i].wr, VEC[i].wdata);
      chk($sformatf("R%0d err vec %0d", VEC[i].req, i), 32'(err_pulse), 32'(VEC[i].exp_err));
      if (!VEC[i].wr)
        chk($sformatf("R%0d data vec %0d", VEC[i].req, i), rsp_rdata, VEC[i].exp);
    end

    // R9: sticky stays, pulse drops after a clean access
    op(1'b0, 1'b0, 32'h0);
    chk("R9 pulse clears", 32'(err_pulse), 32'd0);
    chk("R9 sticky held", 32'(err_sticky), 32'd1);

    // R10: back-pressure on a held read response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_sel = 1'b0; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R10 req_ready low", 32'(req_ready), 32'd0);
    chk("R10 data", rsp_rdata, 32'h08200305);
    req_valid = 1'b1; req_sel = 1'b0; req_write = 1'b1; req_wdata = 32'h00000306;
    @(negedge clk);
    chk("R10 held valid", 32'(rsp_valid), 32'd1);
    chk("R10 held data", rsp_rdata, 32'h08200305);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 released", 32'(rsp_valid), 32'd0);
    op(1'b0, 1'b0, 32'h0);
    chk("R10 stalled write landed", rsp_rdata, 32'h00000306);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule